// File: doc/BRIEF.md
# Slow-Domain Register Write Synchronizer

This block is the bus-side front end for registers that live in a low-power domain clocked at 32.768 kHz. A bus write to a slow register is captured and held while the slow clock makes four rising edges. The write then takes effect through a one-cycle commit strobe, and a completion flag is raised. Only one write can be in flight at a time. A second slow write that arrives inside the window is dropped and raises an error flag; it is not queued. The raw slow clock enters through a flop synchronizer, and its rising edges become single-cycle ticks in the bus clock domain.

A status word reports four things: a busy indicator, a ready-for-next indicator, the completion flag and the error flag. It also carries two event levels fed in from outside, an alarm and a security violation. Reading the status word never stalls and clears the completion flag as a side effect. The error flag is cleared by writing a 1 to it, and that clearing write travels through the same four-tick window as any other slow write. The interrupt-enable register is written at bus speed and bypasses the window entirely. The interrupt output is the OR of every status flag ANDed with its enable bit.

The controller is a three-state machine. ST_IDLE accepts a slow write (transition *accept*). ST_WAIT counts synchronized slow-clock ticks (transition *window_end* on the last tick). ST_DONE commits the write and sets the completion flag, then returns to ST_IDLE (transition *retire*).

Top module: `lp_write_sync`

## Requirements
- R1: After reset, a status read (address 5) returns 0x200: only the next-ready bit 9 is set. An enable read (address 6) returns 0, and irq is low.
- R2: From the cycle after a slow write is accepted until it retires, status shows busy (bit 10) set and next-ready (bit 9) clear.
- R3: Each accepted slow write to an address other than 5 or 6 produces exactly one lp_commit pulse, carrying the captured address and data.
- R4: A write commits after the fourth synchronized rising edge of lp_clk that follows acceptance. With a slow period of 40 bus cycles, this is 110 to 170 bus cycles after acceptance.
- R5: When a slow write retires, the completion flag (status bit 8) is set.
- R6: A status read returns its value in the same cycle and clears the completion flag at the end of that cycle.
- R7: A slow write that arrives while another is in flight sets the error flag (status bit 7) and is discarded; it is never committed.
- R8: Writing address 5 with bit 7 set clears the error flag only when that write retires, after the four-tick window. This write produces no lp_commit pulse.
- R9: A write to address 6 takes effect on the next cycle, even while busy. It keeps only bits 9, 8, 7, 4 and 0, never sets busy, completion or error, and never commits.
- R10: irq is high exactly when some status bit among 9 (next-ready), 8 (complete), 7 (error), 4 (alarm_flag) and 0 (secviol_flag) is set together with the same bit of the enable register.
- R11: If a status read falls in the same cycle as a write retiring, the completion flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| lp_clk | input | 1 | Raw 32.768 kHz slow-domain clock |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | AW | Bus write word address |
| wr_data | input | DW | Bus write data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | AW | Bus read word address |
| rd_data | output | DW | Read data, same cycle |
| alarm_flag | input | 1 | Alarm event level, shown at status bit 4 |
| secviol_flag | input | 1 | Security-violation level, shown at status bit 0 |
| lp_commit | output | 1 | One-cycle strobe applying a write to the slow register |
| lp_addr | output | AW | Address of the committed write |
| lp_data | output | DW | Data of the committed write |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions check the local rules on every cycle. Acceptance raises busy. A commit lasts one cycle and follows busy. The window closes only on a slow tick. Retirement sets the completion flag. A plain status read clears it. Overlap sets the error flag, and the flag falls only on a retiring clear. The enable register changes only when written, and irq needs a nonzero enable. The bench scenarios show the end-to-end effects that no single-cycle property can cover: the four-tick window length measured in bus cycles, a dropped overlapping write that never commits, the deferred error clear, the read-versus-retire collision, and the full enable-by-flag matrix on irq.

// File: rtl/lpws_pkg.sv
package lpws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } wr_state_e;

    // Status / enable bit positions (software decodes these)
    localparam int BIT_BUSY  = 10;
    localparam int BIT_NEXT  = 9;
    localparam int BIT_CMPL  = 8;
    localparam int BIT_ERR   = 7;
    localparam int BIT_ALARM = 4;
    localparam int BIT_SV    = 0;

endpackage

// File: rtl/lpws_edge_sync.sv
module lpws_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_clk,
    output logic tick
);
    // STAGES flops of metastability filtering plus one for edge detection
    logic [STAGES:0] shift_q;

    generate
        for (genvar g = 0; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    shift_q[g] <= 1'b0;
                else if (g == 0)
                    shift_q[g] <= lp_clk;
                else
                    shift_q[g] <= shift_q[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign tick = shift_q[STAGES-1] & ~shift_q[STAGES];

endmodule

// File: rtl/lpws_fsm.sv
module lpws_fsm
    import lpws_pkg::*;
#(
    parameter int AW        = 4,
    parameter int DW        = 32,
    parameter int TICKS     = 4,
    parameter int STAT_ADDR = 5,
    parameter int IEN_ADDR  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          busy_o,
    output logic          overlap_o,
    output logic          done_o,
    output logic          commit_o,
    output logic [AW-1:0] commit_addr_o,
    output logic [DW-1:0] commit_data_o,
    output logic          clr_err_o
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);
    localparam logic [AW-1:0] IEN_A  = AW'(IEN_ADDR);
    localparam logic [CW-1:0] LAST   = CW'(TICKS - 1);

    wr_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          wr_slow;

    assign wr_slow = wr_en && (wr_addr != IEN_A);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept, window_end, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_slow)                  state_d = ST_WAIT;
            ST_WAIT: if (tick && (cnt_q == LAST))  state_d = ST_DONE;
            ST_DONE:                               state_d = ST_IDLE;
            default:                               state_d = ST_IDLE;
        endcase
    end

    // capture and tick counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (state_q == ST_IDLE && wr_slow) begin
            cnt_q  <= '0;
            addr_q <= wr_addr;
            data_q <= wr_data;
        end else if (state_q == ST_WAIT && tick) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy_o        = (state_q != ST_IDLE);
        done_o        = (state_q == ST_DONE);
        overlap_o     = wr_slow && (state_q != ST_IDLE);
        commit_o      = done_o && (addr_q != STAT_A);
        clr_err_o     = done_o && (addr_q == STAT_A) && data_q[BIT_ERR];
        commit_addr_o = addr_q;
        commit_data_o = data_q;
    end

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && wr_slow) |=> busy_o);

    a_r3_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    a_r3_commit_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(busy_o));

    a_r4_window_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(tick));

endmodule

// File: rtl/lpws_flags.sv
module lpws_flags
    import lpws_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic          clr_err_i,
    input  logic          overlap_i,
    input  logic          rd_stat_i,
    input  logic          ien_wr_i,
    input  logic [DW-1:0] ien_wdata_i,
    input  logic          busy_i,
    input  logic          alarm_i,
    input  logic          sv_i,
    output logic [DW-1:0] status_o,
    output logic [DW-1:0] ien_o,
    output logic          irq_o
);
    localparam logic [DW-1:0] IEN_MASK = DW'((32'd1 << BIT_NEXT) | (32'd1 << BIT_CMPL) |
                                             (32'd1 << BIT_ERR)  | (32'd1 << BIT_ALARM) |
                                             (32'd1 << BIT_SV));

    logic          cmpl_q, err_q;
    logic [DW-1:0] ien_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmpl_q <= 1'b0;
            err_q  <= 1'b0;
            ien_q  <= '0;
        end else begin
            // retirement wins over a simultaneous status read
            if (done_i)         cmpl_q <= 1'b1;
            else if (rd_stat_i) cmpl_q <= 1'b0;
            // a fresh overlap wins over a retiring clear
            if (overlap_i)      err_q  <= 1'b1;
            else if (clr_err_i) err_q  <= 1'b0;
            if (ien_wr_i)       ien_q  <= ien_wdata_i & IEN_MASK;
        end
    end

    always_comb begin
        status_o            = '0;
        status_o[BIT_BUSY]  = busy_i;
        status_o[BIT_NEXT]  = !busy_i;
        status_o[BIT_CMPL]  = cmpl_q;
        status_o[BIT_ERR]   = err_q;
        status_o[BIT_ALARM] = alarm_i;
        status_o[BIT_SV]    = sv_i;
        ien_o               = ien_q;
        irq_o               = |(status_o & ien_q);
    end

    a_r5_retire_sets_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> cmpl_q);

    a_r6_read_clears_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_i && !done_i) |=> !cmpl_q);

    a_r7_overlap_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_i |=> err_q);

    a_r8_err_falls_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_q) |-> $past(clr_err_i));

    a_r9_ien_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ien_q) |-> $past(ien_wr_i));

    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ien_q != '0));

endmodule

// File: rtl/lp_write_sync.sv
module lp_write_sync
    import lpws_pkg::*;
#(
    parameter int AW          = 4,
    parameter int DW          = 32,
    parameter int WRITE_TICKS = 4,
    parameter int SYNC_STAGES = 2,
    parameter int STAT_ADDR   = 5,
    parameter int IEN_ADDR    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lp_clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          alarm_flag,
    input  logic          secviol_flag,
    output logic          lp_commit,
    output logic [AW-1:0] lp_addr,
    output logic [DW-1:0] lp_data,
    output logic          irq
);
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);
    localparam logic [AW-1:0] IEN_A  = AW'(IEN_ADDR);

    logic          tick, busy, overlap, done, clr_err;
    logic [DW-1:0] status, ien;

    lpws_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .lp_clk (lp_clk),
        .tick   (tick)
    );

    lpws_fsm #(
        .AW(AW), .DW(DW), .TICKS(WRITE_TICKS),
        .STAT_ADDR(STAT_ADDR), .IEN_ADDR(IEN_ADDR)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .busy_o        (busy),
        .overlap_o     (overlap),
        .done_o        (done),
        .commit_o      (lp_commit),
        .commit_addr_o (lp_addr),
        .commit_data_o (lp_data),
        .clr_err_o     (clr_err)
    );

    lpws_flags #(.DW(DW)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (done),
        .clr_err_i   (clr_err),
        .overlap_i   (overlap),
        .rd_stat_i   (rd_en && (rd_addr == STAT_A)),
        .ien_wr_i    (wr_en && (wr_addr == IEN_A)),
        .ien_wdata_i (wr_data),
        .busy_i      (busy),
        .alarm_i     (alarm_flag),
        .sv_i        (secviol_flag),
        .status_o    (status),
        .ien_o       (ien),
        .irq_o       (irq)
    );

    always_comb begin
        if (rd_addr == STAT_A)     rd_data = status;
        else if (rd_addr == IEN_A) rd_data = ien;
        else                       rd_data = '0;
    end

endmodule

// File: tb/lp_write_sync_test.sv
module lp_write_sync_test;

    localparam int LP_HALF = 20;
    localparam logic [3:0] A_STAT = 4'd5;
    localparam logic [3:0] A_IEN  = 4'd6;

    logic        clk = 0, rst_n = 0, lp_clk = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [3:0]  wr_addr = 0, rd_addr = 0;
    logic [31:0] wr_data = 0, rd_data;
    logic        alarm_flag = 0, secviol_flag = 0;
    logic        lp_commit, irq;
    logic [3:0]  lp_addr;
    logic [31:0] lp_data;

    int checks = 0, errors = 0, cyc = 0;
    int n_commit = 0, t_commit = 0;
    logic [3:0]  last_addr = 0;
    logic [31:0] last_data = 0;
    bit finished = 0;

    lp_write_sync uut (
        .clk(clk), .rst_n(rst_n), .lp_clk(lp_clk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .alarm_flag(alarm_flag), .secviol_flag(secviol_flag),
        .lp_commit(lp_commit), .lp_addr(lp_addr), .lp_data(lp_data), .irq(irq)
    );

    always #2 clk = ~clk;
    initial forever begin
        repeat (LP_HALF) @(posedge clk);
        #1 lp_clk = ~lp_clk;
    end
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (lp_commit) begin
        n_commit++;
        t_commit  = cyc;
        last_addr = lp_addr;
        last_data = lp_data;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk); rd_en = 1; rd_addr = a;
        #1 v = rd_data;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wait_commit(input int n0);
        for (int i = 0; i < 400; i++) begin
            if (n_commit > n0) return;
            @(negedge clk);
        end
        chk("R3 commit timeout", n_commit, n0 + 1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_STAT, v); chk("R1 status", v, 32'h200);
        rd(A_IEN, v);  chk("R1 enable", v, 32'h0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_basic;
        logic [31:0] v; int n0, t0;
        n0 = n_commit;
        wr(4'd3, 32'hA5A5_0001); t0 = cyc;
        rd(A_STAT, v); chk("R2 busy set next clear", v, 32'h400);
        wait_commit(n0);
        chk("R3 one commit", n_commit, n0 + 1);
        chk("R3 addr", last_addr, 4'd3);
        chk("R3 data", last_data, 32'hA5A5_0001);
        chk("R4 window lower", (t_commit - t0 >= 110), 1);
        chk("R4 window upper", (t_commit - t0 <= 170), 1);
        rd(A_STAT, v); chk("R5 complete set", v, 32'h300);
        rd(A_STAT, v); chk("R6 read cleared complete", v, 32'h200);
    endtask

    task automatic t_overlap;
        logic [31:0] v; int n0;
        n0 = n_commit;
        wr(4'd2, 32'h1111_2222);
        wr(4'd1, 32'h3333_4444);
        rd(A_STAT, v); chk("R7 error on overlap", v, 32'h480);
        wait_commit(n0);
        repeat (300) @(negedge clk);
        chk("R7 second write dropped", n_commit, n0 + 1);
        chk("R7 first data kept", last_data, 32'h1111_2222);
        chk("R7 first addr kept", last_addr, 4'd2);
        rd(A_STAT, v); chk("R7 status after", v, 32'h380);
    endtask

    task automatic t_errclr;
        logic [31:0] v; int n0;
        n0 = n_commit;
        wr(A_STAT, 32'h80);
        rd(A_STAT, v); chk("R8 error held while busy", v, 32'h480);
        repeat (220) @(negedge clk);
        rd(A_STAT, v); chk("R8 error cleared after window", v, 32'h300);
        chk("R8 no commit for status write", n_commit, n0);
    endtask

    task automatic t_ien_irq;
        logic [31:0] v; int n0;
        n0 = n_commit;
        wr(4'd3, 32'h0000_BEEF);
        wr(A_IEN, 32'h100);
        rd(A_IEN, v);  chk("R9 enable immediate", v, 32'h100);
        rd(A_STAT, v); chk("R9 no error from enable write", v, 32'h400);
        chk("R10 irq low while busy", irq, 0);
        wait_commit(n0);
        @(negedge clk); chk("R10 irq on complete", irq, 1);
        rd(A_STAT, v);
        @(negedge clk); chk("R10 irq drops after read", irq, 0);
        chk("R9 enable write did not commit", n_commit, n0 + 1);
        wr(A_IEN, 32'hFFFF_FFFF);
        rd(A_IEN, v);  chk("R9 unused enable bits dropped", v, 32'h391);
        wr(A_IEN, 32'h200);
        @(negedge clk); chk("R10 irq on next-ready", irq, 1);
        wr(A_IEN, 32'h010);
        @(negedge clk); chk("R10 alarm masked by level", irq, 0);
        alarm_flag = 1;
        @(negedge clk); chk("R10 irq on alarm", irq, 1);
        wr(A_IEN, 32'h001);
        @(negedge clk); chk("R10 alarm masked by enable", irq, 0);
        secviol_flag = 1;
        @(negedge clk); chk("R10 irq on violation", irq, 1);
        rd(A_STAT, v); chk("R10 event bits in status", v, 32'h211);
        wr(A_IEN, 32'h080);
        @(negedge clk); chk("R10 no error no irq", irq, 0);
        alarm_flag = 0; secviol_flag = 0;
        wr(A_IEN, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        wr(4'd7, 32'h0000_0077);
        @(negedge clk); rd_en = 1; rd_addr = A_STAT;
        v = 32'h400;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); #1 v = rd_data;
            if (!v[10]) break;
        end
        chk("R11 complete survives colliding read", v[8], 1);
        @(negedge clk); #1 v = rd_data;
        chk("R6 following read sees cleared", v[8], 0);
        rd_en = 0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_basic;
        t_overlap;
        t_errclr;
        t_ien_irq;
        t_collide;
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule